// File: doc/BRIEF.md
# Two-Speed Start-Up Clock Controller

This block chooses the clock that feeds the processor core after a reset or after a wake from sleep. When a crystal-based primary oscillator is configured and the two-speed option is enabled, the core starts at once on an always-running internal oscillator. Meanwhile a start-up counter in the primary clock domain waits for the crystal to settle. When that count completes, the block moves the core onto the primary clock by itself and raises a status flag that software can read.

The block drives the two select lines of an external glitch-free clock multiplexer and reads back that multiplexer's per-source acknowledge signals. It drops the current select, waits until both acknowledges are low, and only then raises the new select. Software can override the start-up in two ways while the core still runs on the internal oscillator. It can ask for the internal source, which cancels the automatic switch. It can issue a sleep request, which stops the core and discards the pending start-up.

Top module: `twospeed_clk_ctrl`

## Requirements
- R1: From reset until `pwrt_done` is seen, `run_mode` is 0 (off), both selects are low and `osc_stat` is 0.
- R2: If `two_speed_en` is 1 and `pri_mode` is a crystal mode (codes 0 to 3), the core runs on the internal clock once `pwrt_done` rises. In that state `run_mode` is 1, `sel_int` is 1 and `osc_stat` is 0.
- R3: The block does not switch to the primary clock before `OST_CYCLES` primary cycles have passed since start-up began. After that it switches without any software action, within 48 primary cycles. It then shows `run_mode` 2, `sel_pri` 1, `sel_int` 0 and `osc_stat` 1.
- R4: With `pri_mode` 3 (crystal with PLL), a further `PLL_LOCK_CYCLES` primary cycles are added to the wait before the switch.
- R5: With a crystal mode and `two_speed_en` 0, the core is held unclocked (`run_mode` 3, both selects low) until the start-up count completes. The block then switches to the primary clock.
- R6: For `pri_mode` codes 4 to 7, no start-up count is applied and the enable bit has no effect. The block selects the primary clock within 16 internal cycles and never raises `sel_int`.
- R7: A `sleep_req` pulse in any running state gives `run_mode` 0 with both selects low on the next cycle. It also cancels any pending switch, so the block stays off until a wake.
- R8: A `wake_req` pulse while asleep repeats the start-up sequence, and the start-up count begins again from zero.
- R9: If `clk_sel_sw` is any value other than 00 during internal start-up, the core stays on the internal clock (`run_mode` 1, `osc_stat` 0), even after the start-up count expires.
- R10: When `clk_sel_sw` returns to 00 from internal run, the core keeps the internal clock, whatever `two_speed_en` is, until the primary is ready. It then switches to the primary clock.
- R11: `osc_stat` is 1 only while `sel_pri` is high and `ack_pri` confirms it.
- R12: `sel_int` and `sel_pri` are never high together. A select rises only while the other source's acknowledge is low.
- R13: In primary run, setting `clk_sel_sw` to a value other than 00 hands the core back to the internal clock: `run_mode` 1, `osc_stat` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_int | input | 1 | Internal oscillator clock; clocks the control logic |
| clk_pri | input | 1 | Primary oscillator clock; clocks the start-up counter |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwrt_done | input | 1 | Power-up timer has expired |
| wake_req | input | 1 | Wake-from-sleep pulse |
| sleep_req | input | 1 | Sleep request pulse |
| two_speed_en | input | 1 | Configuration enable for two-speed start-up |
| pri_mode | input | 3 | Primary mode: 0..3 crystal (3 = with PLL), 4..7 non-crystal |
| clk_sel_sw | input | 2 | Software clock select: 00 primary, other values internal |
| ack_int | input | 1 | Mux acknowledge that the internal clock is passing |
| ack_pri | input | 1 | Mux acknowledge that the primary clock is passing |
| sel_int | output | 1 | Select request for the internal clock |
| sel_pri | output | 1 | Select request for the primary clock |
| osc_stat | output | 1 | Primary clock is driving the core |
| run_mode | output | 2 | 0 off, 1 internal run, 2 primary run, 3 waiting/handover |

## Verification
The properties assume that the multiplexer's acknowledges follow their selects with a delay of a few cycles and never rise without a select. They also assume that `sleep_req` and `wake_req` are single-cycle pulses synchronous to `clk_int`, and that `pri_mode` and `two_speed_en` change only while reset is held. The bench models the multiplexer as two-flop followers, one in each clock domain. It changes the configuration only inside reset and drives the request pulses on the falling edge of the internal clock, so the stimulus stays inside these assumptions.

// File: rtl/tsu_pkg.sv
package tsu_pkg;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_WARM,
        ST_REL,
        ST_GRANT,
        ST_PRI,
        ST_INT
    } tsu_state_e;

    typedef enum logic [1:0] {
        RM_OFF  = 2'd0,
        RM_INT  = 2'd1,
        RM_PRI  = 2'd2,
        RM_WAIT = 2'd3
    } run_mode_e;

    typedef struct packed {
        tsu_state_e st;
        logic       hold;
        logic       tgt_pri;
        logic       por;
        logic       wake;
    } fsm_reg_t;

    function automatic logic is_crystal(input logic [2:0] m);
        return (m <= 3'd3);
    endfunction

    function automatic logic is_pll(input logic [2:0] m);
        return (m == 3'd3);
    endfunction

endpackage

// File: rtl/bit_sync.sv
module bit_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], d};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign q = sh_q[STAGES-1];
endmodule

// File: rtl/ost_timer.sv
module ost_timer #(
    parameter int OST_CYCLES      = 1024,
    parameter int PLL_LOCK_CYCLES = 2048,
    parameter int SYNC_STAGES     = 2
) (
    input  logic clk_pri,
    input  logic rst_n,
    input  logic run,
    input  logic pll_mode,
    output logic done
);
    localparam int TOTAL = OST_CYCLES + PLL_LOCK_CYCLES;
    localparam int CW    = $clog2(TOTAL + 1);
    localparam logic [CW-1:0] LIM_BASE = CW'(OST_CYCLES);
    localparam logic [CW-1:0] LIM_PLL  = CW'(TOTAL);

    logic          run_s;
    logic [CW-1:0] limit;
    logic [CW-1:0] cnt_d, cnt_q;
    logic          done_d, done_q;

    bit_sync #(.STAGES(SYNC_STAGES)) u_run_sync (
        .clk   (clk_pri),
        .rst_n (rst_n),
        .d     (run),
        .q     (run_s)
    );

    always_comb begin
        limit = pll_mode ? LIM_PLL : LIM_BASE;
        cnt_d = cnt_q;
        if (!run_s)
            cnt_d = '0;
        else if (cnt_q != limit)
            cnt_d = cnt_q + 1'b1;
        done_d = run_s && (cnt_d == limit);
    end

    always_ff @(posedge clk_pri or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            done_q <= 1'b0;
        end else begin
            cnt_q  <= cnt_d;
            done_q <= done_d;
        end
    end

    assign done = done_q;
endmodule

// File: rtl/startup_fsm.sv
module startup_fsm
    import tsu_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pwrt_done,
    input  logic       wake_req,
    input  logic       sleep_req,
    input  logic       two_speed_en,
    input  logic [2:0] pri_mode,
    input  logic [1:0] clk_sel_sw,
    input  logic       ack_int,
    input  logic       ack_pri,
    input  logic       ost_done,
    output logic       sel_int,
    output logic       sel_pri,
    output logic       osc_stat,
    output logic [1:0] run_mode,
    output logic       ost_run
);
    fsm_reg_t r_d, r_q;
    logic     want_int, crystal, ready, start_ok;

    always_comb begin
        r_d      = r_q;
        want_int = (clk_sel_sw != 2'b00);
        crystal  = is_crystal(pri_mode);
        ready    = !crystal || ost_done;
        start_ok = r_q.por ? pwrt_done : (r_q.wake || wake_req);

        case (r_q.st)
            ST_OFF: begin
                if (wake_req) r_d.wake = 1'b1;
                if (start_ok && !ost_done) begin
                    r_d.st   = ST_WARM;
                    r_d.hold = two_speed_en && crystal;
                    r_d.por  = 1'b0;
                    r_d.wake = 1'b0;
                end
            end
            ST_WARM: begin
                if (r_q.hold && want_int) begin
                    r_d.st = ST_INT;
                end else if (ready) begin
                    r_d.st      = ST_REL;
                    r_d.tgt_pri = 1'b1;
                end
            end
            ST_REL: begin
                if (!ack_int && !ack_pri) r_d.st = ST_GRANT;
            end
            ST_GRANT: begin
                if (r_q.tgt_pri ? ack_pri : ack_int)
                    r_d.st = r_q.tgt_pri ? ST_PRI : ST_INT;
            end
            ST_PRI: begin
                if (want_int) begin
                    r_d.st      = ST_REL;
                    r_d.tgt_pri = 1'b0;
                end
            end
            ST_INT: begin
                if (!want_int) begin
                    r_d.st   = ST_WARM;
                    r_d.hold = 1'b1;
                end
            end
            default: r_d.st = ST_OFF;
        endcase

        if (sleep_req && (r_q.st != ST_OFF)) begin
            r_d.st   = ST_OFF;
            r_d.por  = 1'b0;
            r_d.wake = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st      <= ST_OFF;
            r_q.hold    <= 1'b0;
            r_q.tgt_pri <= 1'b0;
            r_q.por     <= 1'b1;
            r_q.wake    <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        sel_int  = ((r_q.st == ST_WARM) && r_q.hold) || (r_q.st == ST_INT) ||
                   ((r_q.st == ST_GRANT) && !r_q.tgt_pri);
        sel_pri  = (r_q.st == ST_PRI) || ((r_q.st == ST_GRANT) && r_q.tgt_pri);
        osc_stat = (r_q.st == ST_PRI);
        ost_run  = (r_q.st != ST_OFF);
        case (r_q.st)
            ST_OFF:  run_mode = RM_OFF;
            ST_WARM: run_mode = r_q.hold ? RM_INT : RM_WAIT;
            ST_INT:  run_mode = RM_INT;
            ST_PRI:  run_mode = RM_PRI;
            default: run_mode = RM_WAIT;
        endcase
    end
endmodule

// File: rtl/twospeed_clk_ctrl.sv
module twospeed_clk_ctrl
    import tsu_pkg::*;
#(
    parameter int OST_CYCLES      = 1024,
    parameter int PLL_LOCK_CYCLES = 2048,
    parameter int SYNC_STAGES     = 2
) (
    input  logic       clk_int,
    input  logic       clk_pri,
    input  logic       rst_n,
    input  logic       pwrt_done,
    input  logic       wake_req,
    input  logic       sleep_req,
    input  logic       two_speed_en,
    input  logic [2:0] pri_mode,
    input  logic [1:0] clk_sel_sw,
    input  logic       ack_int,
    input  logic       ack_pri,
    output logic       sel_int,
    output logic       sel_pri,
    output logic       osc_stat,
    output logic [1:0] run_mode
);
    logic ost_run, done_pri, done_sync;

    ost_timer #(
        .OST_CYCLES      (OST_CYCLES),
        .PLL_LOCK_CYCLES (PLL_LOCK_CYCLES),
        .SYNC_STAGES     (SYNC_STAGES)
    ) u_ost (
        .clk_pri  (clk_pri),
        .rst_n    (rst_n),
        .run      (ost_run),
        .pll_mode (is_pll(pri_mode)),
        .done     (done_pri)
    );

    bit_sync #(.STAGES(SYNC_STAGES)) u_done_sync (
        .clk   (clk_int),
        .rst_n (rst_n),
        .d     (done_pri),
        .q     (done_sync)
    );

    startup_fsm u_fsm (
        .clk          (clk_int),
        .rst_n        (rst_n),
        .pwrt_done    (pwrt_done),
        .wake_req     (wake_req),
        .sleep_req    (sleep_req),
        .two_speed_en (two_speed_en),
        .pri_mode     (pri_mode),
        .clk_sel_sw   (clk_sel_sw),
        .ack_int      (ack_int),
        .ack_pri      (ack_pri),
        .ost_done     (done_sync),
        .sel_int      (sel_int),
        .sel_pri      (sel_pri),
        .osc_stat     (osc_stat),
        .run_mode     (run_mode),
        .ost_run      (ost_run)
    );
endmodule

// File: rtl/tsu_chk.sv
module tsu_chk (
    input logic       clk_int,
    input logic       rst_n,
    input logic       sleep_req,
    input logic       ack_int,
    input logic       ack_pri,
    input logic       sel_int,
    input logic       sel_pri,
    input logic       osc_stat,
    input logic [1:0] run_mode
);
    // R12
    no_overlap_chk: assert property (@(posedge clk_int) disable iff (!rst_n)
        !(sel_int && sel_pri));

    // R12
    pri_after_release_chk: assert property (@(posedge clk_int) disable iff (!rst_n)
        $rose(sel_pri) |-> !ack_int);

    // R12
    int_after_release_chk: assert property (@(posedge clk_int) disable iff (!rst_n)
        $rose(sel_int) |-> !ack_pri);

    // R11
    stat_backed_chk: assert property (@(posedge clk_int) disable iff (!rst_n)
        osc_stat |-> (sel_pri && ack_pri));

    // R2
    int_run_chk: assert property (@(posedge clk_int) disable iff (!rst_n)
        (run_mode == 2'd1) |-> (sel_int && !osc_stat));

    // R7
    sleep_stop_chk: assert property (@(posedge clk_int) disable iff (!rst_n)
        (sleep_req && (run_mode != 2'd0)) |=> ((run_mode == 2'd0) && !sel_int && !sel_pri));
endmodule

bind twospeed_clk_ctrl tsu_chk u_chk (
    .clk_int   (clk_int),
    .rst_n     (rst_n),
    .sleep_req (sleep_req),
    .ack_int   (ack_int),
    .ack_pri   (ack_pri),
    .sel_int   (sel_int),
    .sel_pri   (sel_pri),
    .osc_stat  (osc_stat),
    .run_mode  (run_mode)
);

// File: tb/sim_twospeed_clk_ctrl.sv
`timescale 1ns/1ps
module sim_twospeed_clk_ctrl;
    localparam int OST = 1024;
    localparam int PLL = 256;

    logic       clk_int = 1'b0, clk_pri = 1'b0, rst_n = 1'b0;
    logic       pwrt_done = 1'b0, wake_req = 1'b0, sleep_req = 1'b0;
    logic       two_speed_en = 1'b0;
    logic [2:0] pri_mode = 3'd1;
    logic [1:0] clk_sel_sw = 2'b00;
    logic       ack_int, ack_pri, sel_int, sel_pri, osc_stat;
    logic [1:0] run_mode;
    logic [1:0] ai_sh, ap_sh;

    int n_cmp = 0, n_bad = 0, overlap = 0;
    bit done_flag = 0;

    always #5 clk_int = ~clk_int;
    always #4 clk_pri = ~clk_pri;

    // mux model: acknowledges follow the selects through two flops of their own clock
    always_ff @(posedge clk_int or negedge rst_n)
        if (!rst_n) ai_sh <= '0; else ai_sh <= {ai_sh[0], sel_int};
    always_ff @(posedge clk_pri or negedge rst_n)
        if (!rst_n) ap_sh <= '0; else ap_sh <= {ap_sh[0], sel_pri};
    assign ack_int = ai_sh[1];
    assign ack_pri = ap_sh[1];

    twospeed_clk_ctrl #(.OST_CYCLES(OST), .PLL_LOCK_CYCLES(PLL)) u0 (
        .clk_int(clk_int), .clk_pri(clk_pri), .rst_n(rst_n), .pwrt_done(pwrt_done),
        .wake_req(wake_req), .sleep_req(sleep_req), .two_speed_en(two_speed_en),
        .pri_mode(pri_mode), .clk_sel_sw(clk_sel_sw), .ack_int(ack_int), .ack_pri(ack_pri),
        .sel_int(sel_int), .sel_pri(sel_pri), .osc_stat(osc_stat), .run_mode(run_mode)
    );

    always @(negedge clk_int) if (sel_int && sel_pri) overlap++;

    typedef struct {
        string      tag;
        logic       si;
        logic       sp;
        logic       st;
        logic [1:0] rm;
    } exp_t;
    exp_t exp_q[$];
    event smp;

    // monitor: pops expectations and compares with the outputs
    initial begin
        forever begin
            @(smp);
            while (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                n_cmp++;
                if (sel_int !== e.si || sel_pri !== e.sp || osc_stat !== e.st || run_mode !== e.rm) begin
                    n_bad++;
                    $display("FAIL %s: got si=%b sp=%b st=%b rm=%0d, exp si=%b sp=%b st=%b rm=%0d",
                             e.tag, sel_int, sel_pri, osc_stat, run_mode, e.si, e.sp, e.st, e.rm);
                end
            end
        end
    end

    task automatic expect_state(input string tag, input logic si, input logic sp,
                                input logic st, input logic [1:0] rm);
        exp_t e;
        e.tag = tag; e.si = si; e.sp = sp; e.st = st; e.rm = rm;
        exp_q.push_back(e);
        ->smp;
        #1;
    endtask

    task automatic chk(input string tag, input bit ok, input int act, input int exp_v);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: got %0d, exp %0d", tag, act, exp_v);
        end
    endtask

    task automatic int_wait(input int n);
        repeat (n) @(negedge clk_int);
    endtask

    task automatic pri_wait(input int n);
        repeat (n) @(posedge clk_pri);
        @(negedge clk_int);
    endtask

    task automatic do_reset(input logic en, input logic [2:0] mode);
        @(negedge clk_int);
        rst_n = 1'b0; pwrt_done = 1'b0; clk_sel_sw = 2'b00;
        two_speed_en = en; pri_mode = mode;
        int_wait(4);
        rst_n = 1'b1;
        int_wait(2);
    endtask

    task automatic pulse_sleep();
        sleep_req = 1'b1;
        int_wait(1);
        sleep_req = 1'b0;
    endtask

    task automatic pulse_wake();
        wake_req = 1'b1;
        int_wait(1);
        wake_req = 1'b0;
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        #1500000;
        n_cmp++; n_bad++;
        $display("FAIL watchdog: got timeout, exp completion");
        finish_run();
    end

    initial begin
        // R1 reset state, crystal mode with two-speed enabled
        do_reset(1'b1, 3'd1);
        int_wait(3);
        expect_state("R1 reset idle", 0, 0, 0, 2'd0);
        pwrt_done = 1'b1;
        int_wait(6);
        expect_state("R2 internal start", 1, 0, 0, 2'd1);
        pri_wait(980);
        expect_state("R3 no early switch", 1, 0, 0, 2'd1);
        pri_wait(100);
        expect_state("R3 auto switch", 0, 1, 1, 2'd2);
        chk("R11 status backed by ack", (osc_stat && ack_pri), int'(ack_pri), 1);

        // R13 primary run back to internal
        clk_sel_sw = 2'b10;
        int_wait(12);
        expect_state("R13 back to internal", 1, 0, 0, 2'd1);
        // R10 return to primary request, primary already stable
        clk_sel_sw = 2'b00;
        int_wait(15);
        expect_state("R10 switch to ready primary", 0, 1, 1, 2'd2);

        // R7 sleep, R8 wake restarts the count
        pulse_sleep();
        expect_state("R7 sleep from primary", 0, 0, 0, 2'd0);
        int_wait(10);
        pulse_wake();
        int_wait(10);
        expect_state("R8 wake on internal", 1, 0, 0, 2'd1);
        pri_wait(900);
        expect_state("R8 count restarted", 1, 0, 0, 2'd1);
        // R9 software holds internal clock
        clk_sel_sw = 2'b01;
        int_wait(3);
        expect_state("R9 internal run", 1, 0, 0, 2'd1);
        pri_wait(300);
        expect_state("R9 switch cancelled", 1, 0, 0, 2'd1);
        clk_sel_sw = 2'b00;
        int_wait(15);
        expect_state("R10 resume primary", 0, 1, 1, 2'd2);

        // R7 sleep pre-empts pending switch
        pulse_sleep();
        int_wait(10);
        pulse_wake();
        int_wait(10);
        expect_state("R8 second wake", 1, 0, 0, 2'd1);
        pri_wait(500);
        pulse_sleep();
        expect_state("R7 sleep during start-up", 0, 0, 0, 2'd0);
        pri_wait(1000);
        expect_state("R7 switch cancelled", 0, 0, 0, 2'd0);

        // R5 enable clear, crystal mode
        do_reset(1'b0, 3'd2);
        pwrt_done = 1'b1;
        int_wait(6);
        expect_state("R5 waiting unclocked", 0, 0, 0, 2'd3);
        pri_wait(980);
        expect_state("R5 still waiting", 0, 0, 0, 2'd3);
        pri_wait(100);
        expect_state("R5 switch to primary", 0, 1, 1, 2'd2);

        // R4 crystal with PLL adds lock time
        do_reset(1'b1, 3'd3);
        pwrt_done = 1'b1;
        int_wait(6);
        expect_state("R4 internal start", 1, 0, 0, 2'd1);
        pri_wait(OST + PLL - 30);
        expect_state("R4 waits for lock", 1, 0, 0, 2'd1);
        pri_wait(90);
        expect_state("R4 switch after lock", 0, 1, 1, 2'd2);

        // R6 non-crystal mode ignores enable and timer
        do_reset(1'b1, 3'd4);
        pwrt_done = 1'b1;
        begin
            int seen = 0;
            for (int i = 0; i < 16; i++) begin
                int_wait(1);
                if (sel_int) seen++;
            end
            chk("R6 internal never selected", seen == 0, seen, 0);
        end
        expect_state("R6 fast primary", 0, 1, 1, 2'd2);

        // R12 selects never overlapped during the run
        chk("R12 select overlap count", overlap == 0, overlap, 0);

        finish_run();
    end
endmodule